// File: doc/BRIEF.md
# Control-Word Insert and Monitor Tables

This block keeps two tables of link control words, one entry for each basic-frame position X in a hyperframe (256 positions by default). The transmit table holds words that may be substituted into the outgoing stream, and each transmit entry carries its own substitute flag. The receive table records the last control word seen at each position on the incoming stream.

A processor reaches both tables through a small register window. A selector register chooses an entry and a 32-bit section for each table. A transmit window register and a receive window register then move that one section. Reads return one cycle after the read strobe.

On the link side, every valid strobe brings a position number and a full control word. One cycle later the block presents either the word unchanged or the stored transmit entry. It also writes the incoming word into the receive table at that position. A mode input selects between a four-section (128-bit) word and an extended five-section (160-bit) word.

Top module: `ctrlword_tables`

## Requirements
- R1: After reset every selector field, every stored flag, every table section and every output reads zero.
- R2: Register address 0 is the selector. Transmit position is in bits 7:0, transmit section in bits 10:8, the substitute flag in bit 11, receive position in bits 23:16 and receive section in bits 26:24. The position and section fields read back as last written.
- R3: Selector bits 31:27 and 15:12 always read as zero, whatever was written to them.
- R4: A selector write stores bit 11 as the substitute flag of the entry named by the newly written transmit position. Bit 11 on read shows the stored flag of the currently selected transmit entry. Flags of other entries are kept.
- R5: A write to address 1 (transmit window) changes only the selected section of the selected transmit entry. A read of address 1 returns that section.
- R6: Section codes 0 to 3 are always valid, and code 4 is valid only when ext_mode_i is high. A window read at an invalid code returns zero, and a transmit window write at an invalid code changes nothing.
- R7: When lnk_vld_i is high, lnk_vld_o is high on the next cycle and lnk_cw_o carries the substituted word if the entry at lnk_x_i has its flag set and ins_en_i is high. Otherwise it carries lnk_cw_i unchanged. Section s occupies bits 32s+31:32s.
- R8: In four-section mode a substitution replaces only bits 127:0, and bits 159:128 pass through from lnk_cw_i. In extended mode all 160 bits are replaced.
- R9: Every valid link word is stored at its position in the receive table, and address 2 (receive window) returns the selected section of that stored word.
- R10: A transmit window write that lands in the same cycle as the substitution of that entry does not affect that output word. It takes effect from the next visit to the position.
- R11: reg_rvalid_o pulses exactly one cycle after each read strobe, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the register and link sides |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | High selects five-section control words |
| ins_en_i | input | 1 | Global substitute enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address (0 selector, 1 tx window, 2 rx window, 3 spare) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| reg_rdata_o | output | 32 | Read data |
| lnk_vld_i | input | 1 | Incoming basic-frame strobe |
| lnk_x_i | input | 8 | Basic-frame position of the incoming word |
| lnk_cw_i | input | 160 | Incoming control word |
| lnk_vld_o | output | 1 | Outgoing basic-frame strobe |
| lnk_cw_o | output | 160 | Outgoing control word |

## Verification
The bench builds the block with its default parameters: 8-bit positions (256 entries per table), 32-bit sections and five sections per word. With these values every position, the extended fifth section, and the zero read at section codes 4 to 7 can all be reached. The run toggles ext_mode_i, so one stored word is seen both as a 128-bit and as a 160-bit substitution. A collision between a window write and a link visit to the same entry is also forced.

// File: rtl/ctw_pkg.sv
package ctw_pkg;

    localparam int SEL_W    = 3;
    localparam int TXI_LSB  = 0;
    localparam int TXS_LSB  = 8;
    localparam int FLAG_BIT = 11;
    localparam int RXI_LSB  = 16;
    localparam int RXS_LSB  = 24;

    typedef enum logic [1:0] {
        CTW_A_INDEX = 2'd0,
        CTW_A_TXWIN = 2'd1,
        CTW_A_RXWIN = 2'd2,
        CTW_A_SPARE = 2'd3
    } ctw_addr_e;

    // A section code is usable when it addresses a section that exists in the current mode.
    function automatic logic sec_in_range(logic [SEL_W-1:0] sec, logic ext, int n_sec);
        int lim;
        lim = ext ? n_sec : n_sec - 1;
        return (int'(sec) < lim);
    endfunction

endpackage

// File: rtl/ctw_index_reg.sv
module ctw_index_reg
    import ctw_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int N_SEC = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [X_W-1:0]   tx_idx_i,
    input  logic [SEL_W-1:0] tx_sec_i,
    input  logic [X_W-1:0]   rx_idx_i,
    input  logic [SEL_W-1:0] rx_sec_i,
    input  logic             ext_mode_i,
    output logic [X_W-1:0]   tx_idx_o,
    output logic [SEL_W-1:0] tx_sec_o,
    output logic [X_W-1:0]   rx_idx_o,
    output logic [SEL_W-1:0] rx_sec_o,
    output logic             tx_sec_ok_o,
    output logic             rx_sec_ok_o
);

    typedef struct packed {
        logic [X_W-1:0]   tx_idx;
        logic [SEL_W-1:0] tx_sec;
        logic [X_W-1:0]   rx_idx;
        logic [SEL_W-1:0] rx_sec;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_i) begin
            sel_d.tx_idx = tx_idx_i;
            sel_d.tx_sec = tx_sec_i;
            sel_d.rx_idx = rx_idx_i;
            sel_d.rx_sec = rx_sec_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign tx_idx_o    = sel_q.tx_idx;
    assign tx_sec_o    = sel_q.tx_sec;
    assign rx_idx_o    = sel_q.rx_idx;
    assign rx_sec_o    = sel_q.rx_sec;
    assign tx_sec_ok_o = sec_in_range(sel_q.tx_sec, ext_mode_i, N_SEC);
    assign rx_sec_ok_o = sec_in_range(sel_q.rx_sec, ext_mode_i, N_SEC);

    // R2
    sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(tx_idx_o) && $stable(tx_sec_o) && $stable(rx_idx_o) && $stable(rx_sec_o));

    // R2
    sel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (tx_idx_o == $past(tx_idx_i)) && (rx_idx_o == $past(rx_idx_i))
              && (tx_sec_o == $past(tx_sec_i)) && (rx_sec_o == $past(rx_sec_i)));

endmodule

// File: rtl/ctw_tx_table.sv
module ctw_tx_table
    import ctw_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int SEC_W = 32,
    parameter int N_SEC = 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [X_W-1:0]         sel_idx_i,
    input  logic [SEL_W-1:0]       sel_sec_i,
    input  logic                   sel_ok_i,
    input  logic                   win_we_i,
    input  logic [SEC_W-1:0]       win_wdata_i,
    input  logic                   flag_we_i,
    input  logic [X_W-1:0]         flag_idx_i,
    input  logic                   flag_val_i,
    input  logic                   ext_mode_i,
    input  logic                   ins_en_i,
    input  logic                   lnk_vld_i,
    input  logic [X_W-1:0]         lnk_x_i,
    input  logic [SEC_W*N_SEC-1:0] lnk_cw_i,
    output logic [SEC_W-1:0]       win_rdata_o,
    output logic                   sel_flag_o,
    output logic                   lnk_vld_o,
    output logic [SEC_W*N_SEC-1:0] lnk_cw_o
);

    localparam int NUM_POS  = 1 << X_W;
    localparam int CW_W     = SEC_W * N_SEC;
    localparam int NORM_SEC = N_SEC - 1;

    typedef logic [N_SEC-1:0][SEC_W-1:0] cw_t;

    typedef struct packed {
        logic             win_we;
        logic [X_W-1:0]   win_idx;
        logic [SEL_W-1:0] win_sec;
        logic [SEC_W-1:0] win_data;
        logic             flag_we;
        logic [X_W-1:0]   flag_idx;
        logic             flag_val;
        logic             out_vld;
        logic [CW_W-1:0]  out_cw;
    } tx_next_t;

    typedef struct packed {
        logic            vld;
        logic [CW_W-1:0] cw;
    } tx_out_t;

    cw_t                tab_q [NUM_POS];
    logic [NUM_POS-1:0] flag_q;
    tx_next_t           nx_d;
    tx_out_t            out_q;

    cw_t              src_cw;
    cw_t              ent_cw;
    cw_t              mix_cw;
    logic             hit;
    logic [SEL_W-1:0] sec_c;

    assign src_cw = lnk_cw_i;
    assign ent_cw = tab_q[lnk_x_i];
    assign hit    = flag_q[lnk_x_i] & ins_en_i;

    // Base sections always follow the hit; the extended section also needs the mode.
    for (genvar s = 0; s < N_SEC; s++) begin : g_mix
        if (s < NORM_SEC) begin : g_base
            assign mix_cw[s] = hit ? ent_cw[s] : src_cw[s];
        end else begin : g_ext
            assign mix_cw[s] = (hit && ext_mode_i) ? ent_cw[s] : src_cw[s];
        end
    end

    assign sec_c = sel_ok_i ? sel_sec_i : '0;

    always_comb begin
        nx_d          = '0;
        nx_d.win_we   = win_we_i && sel_ok_i;
        nx_d.win_idx  = sel_idx_i;
        nx_d.win_sec  = sec_c;
        nx_d.win_data = win_wdata_i;
        nx_d.flag_we  = flag_we_i;
        nx_d.flag_idx = flag_idx_i;
        nx_d.flag_val = flag_val_i;
        nx_d.out_vld  = lnk_vld_i;
        nx_d.out_cw   = lnk_vld_i ? mix_cw : out_q.cw;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_POS; i++) begin
                tab_q[i] <= '0;
            end
            flag_q <= '0;
            out_q  <= '0;
        end else begin
            if (nx_d.win_we) begin
                tab_q[nx_d.win_idx][nx_d.win_sec] <= nx_d.win_data;
            end
            if (nx_d.flag_we) begin
                flag_q[nx_d.flag_idx] <= nx_d.flag_val;
            end
            out_q.vld <= nx_d.out_vld;
            out_q.cw  <= nx_d.out_cw;
        end
    end

    assign win_rdata_o = sel_ok_i ? tab_q[sel_idx_i][sec_c] : '0;
    assign sel_flag_o  = flag_q[sel_idx_i];
    assign lnk_vld_o   = out_q.vld;
    assign lnk_cw_o    = out_q.cw;

    // R7
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lnk_vld_i |=> lnk_vld_o);

    // R7
    vld_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lnk_vld_i |=> !lnk_vld_o);

    // R7
    passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lnk_vld_i && !ins_en_i |=> lnk_cw_o == $past(lnk_cw_i));

    // R8
    upper_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lnk_vld_i && !ext_mode_i |=>
            lnk_cw_o[CW_W-1:NORM_SEC*SEC_W] == $past(lnk_cw_i[CW_W-1:NORM_SEC*SEC_W]));

    // R4
    flag_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_we_i |=> flag_q[$past(flag_idx_i)] == $past(flag_val_i));

endmodule

// File: rtl/ctw_rx_table.sv
module ctw_rx_table
    import ctw_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int SEC_W = 32,
    parameter int N_SEC = 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [X_W-1:0]         sel_idx_i,
    input  logic [SEL_W-1:0]       sel_sec_i,
    input  logic                   sel_ok_i,
    input  logic                   lnk_vld_i,
    input  logic [X_W-1:0]         lnk_x_i,
    input  logic [SEC_W*N_SEC-1:0] lnk_cw_i,
    output logic [SEC_W-1:0]       win_rdata_o
);

    localparam int NUM_POS = 1 << X_W;
    localparam int CW_W    = SEC_W * N_SEC;

    typedef logic [N_SEC-1:0][SEC_W-1:0] cw_t;

    typedef struct packed {
        logic            we;
        logic [X_W-1:0]  idx;
        logic [CW_W-1:0] cw;
    } cap_t;

    cw_t              rx_q [NUM_POS];
    cap_t             cap_d;
    logic [SEL_W-1:0] sec_c;

    always_comb begin
        cap_d.we  = lnk_vld_i;
        cap_d.idx = lnk_x_i;
        cap_d.cw  = lnk_cw_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_POS; i++) begin
                rx_q[i] <= '0;
            end
        end else if (cap_d.we) begin
            rx_q[cap_d.idx] <= cap_d.cw;
        end
    end

    assign sec_c       = sel_ok_i ? sel_sec_i : '0;
    assign win_rdata_o = sel_ok_i ? rx_q[sel_idx_i][sec_c] : '0;

    // R9
    rx_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lnk_vld_i |=> rx_q[$past(lnk_x_i)] == $past(lnk_cw_i));

    // R6
    rx_bad_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_ok_i |-> win_rdata_o == '0);

endmodule

// File: rtl/ctrlword_tables.sv
module ctrlword_tables
    import ctw_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int SEC_W = 32,
    parameter int N_SEC = 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   ext_mode_i,
    input  logic                   ins_en_i,
    input  logic                   reg_wr_i,
    input  logic                   reg_rd_i,
    input  logic [1:0]             reg_addr_i,
    input  logic [SEC_W-1:0]       reg_wdata_i,
    output logic                   reg_rvalid_o,
    output logic [SEC_W-1:0]       reg_rdata_o,
    input  logic                   lnk_vld_i,
    input  logic [X_W-1:0]         lnk_x_i,
    input  logic [SEC_W*N_SEC-1:0] lnk_cw_i,
    output logic                   lnk_vld_o,
    output logic [SEC_W*N_SEC-1:0] lnk_cw_o
);

    typedef struct packed {
        logic             rvalid;
        logic [SEC_W-1:0] rdata;
    } rd_t;

    logic [X_W-1:0]   tx_idx, rx_idx;
    logic [SEL_W-1:0] tx_sec, rx_sec;
    logic             tx_ok, rx_ok;
    logic             sel_flag;
    logic [SEC_W-1:0] tx_rdata, rx_rdata;
    logic [SEC_W-1:0] idx_word;
    logic             idx_wr, txwin_wr;
    rd_t              rd_d, rd_q;

    assign idx_wr   = reg_wr_i && (reg_addr_i == CTW_A_INDEX);
    assign txwin_wr = reg_wr_i && (reg_addr_i == CTW_A_TXWIN);

    ctw_index_reg #(.X_W(X_W), .N_SEC(N_SEC)) u_sel (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (idx_wr),
        .tx_idx_i   (reg_wdata_i[TXI_LSB +: X_W]),
        .tx_sec_i   (reg_wdata_i[TXS_LSB +: SEL_W]),
        .rx_idx_i   (reg_wdata_i[RXI_LSB +: X_W]),
        .rx_sec_i   (reg_wdata_i[RXS_LSB +: SEL_W]),
        .ext_mode_i (ext_mode_i),
        .tx_idx_o   (tx_idx),
        .tx_sec_o   (tx_sec),
        .rx_idx_o   (rx_idx),
        .rx_sec_o   (rx_sec),
        .tx_sec_ok_o(tx_ok),
        .rx_sec_ok_o(rx_ok)
    );

    ctw_tx_table #(.X_W(X_W), .SEC_W(SEC_W), .N_SEC(N_SEC)) u_tx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_idx_i  (tx_idx),
        .sel_sec_i  (tx_sec),
        .sel_ok_i   (tx_ok),
        .win_we_i   (txwin_wr),
        .win_wdata_i(reg_wdata_i),
        .flag_we_i  (idx_wr),
        .flag_idx_i (reg_wdata_i[TXI_LSB +: X_W]),
        .flag_val_i (reg_wdata_i[FLAG_BIT]),
        .ext_mode_i (ext_mode_i),
        .ins_en_i   (ins_en_i),
        .lnk_vld_i  (lnk_vld_i),
        .lnk_x_i    (lnk_x_i),
        .lnk_cw_i   (lnk_cw_i),
        .win_rdata_o(tx_rdata),
        .sel_flag_o (sel_flag),
        .lnk_vld_o  (lnk_vld_o),
        .lnk_cw_o   (lnk_cw_o)
    );

    ctw_rx_table #(.X_W(X_W), .SEC_W(SEC_W), .N_SEC(N_SEC)) u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_idx_i  (rx_idx),
        .sel_sec_i  (rx_sec),
        .sel_ok_i   (rx_ok),
        .lnk_vld_i  (lnk_vld_i),
        .lnk_x_i    (lnk_x_i),
        .lnk_cw_i   (lnk_cw_i),
        .win_rdata_o(rx_rdata)
    );

    always_comb begin
        idx_word                       = '0;
        idx_word[TXI_LSB +: X_W]       = tx_idx;
        idx_word[TXS_LSB +: SEL_W]     = tx_sec;
        idx_word[FLAG_BIT]             = sel_flag;
        idx_word[RXI_LSB +: X_W]       = rx_idx;
        idx_word[RXS_LSB +: SEL_W]     = rx_sec;
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = reg_rd_i;
        if (reg_rd_i) begin
            case (reg_addr_i)
                CTW_A_INDEX: rd_d.rdata = idx_word;
                CTW_A_TXWIN: rd_d.rdata = tx_rdata;
                CTW_A_RXWIN: rd_d.rdata = rx_rdata;
                default:     rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rvalid_o = rd_q.rvalid;
    assign reg_rdata_o  = rd_q.rdata;

    // R11
    rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rd_i |=> reg_rvalid_o);

    // R11
    rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reg_rd_i |=> !reg_rvalid_o);

    // R11
    spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rd_i && (reg_addr_i == CTW_A_SPARE) |=> reg_rdata_o == '0);

    // R3
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rd_i && (reg_addr_i == CTW_A_INDEX) |=>
            (reg_rdata_o[31:27] == 5'd0) && (reg_rdata_o[15:12] == 4'd0));

    // R6
    tx_bad_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rd_i && (reg_addr_i == CTW_A_TXWIN) && !tx_ok |=> reg_rdata_o == '0);

endmodule

// File: tb/test_ctrlword_tables.sv
module test_ctrlword_tables;

    localparam int CW_W = 160;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ext_mode, ins_en;
    logic             reg_wr, reg_rd;
    logic [1:0]       reg_addr;
    logic [31:0]      reg_wdata;
    logic             reg_rvalid;
    logic [31:0]      reg_rdata;
    logic             lnk_vld;
    logic [7:0]       lnk_x;
    logic [CW_W-1:0]  lnk_cw;
    logic             lnk_vld_o;
    logic [CW_W-1:0]  lnk_cw_o;

    always #4 clk = ~clk;

    ctrlword_tables i_ctrlword_tables (
        .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .ins_en_i(ins_en),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rvalid_o(reg_rvalid), .reg_rdata_o(reg_rdata),
        .lnk_vld_i(lnk_vld), .lnk_x_i(lnk_x), .lnk_cw_i(lnk_cw),
        .lnk_vld_o(lnk_vld_o), .lnk_cw_o(lnk_cw_o)
    );

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] m_tx [256][5];
    logic [31:0] m_rx [256][5];
    bit          m_flag [256];
    logic [7:0]  m_txi, m_rxi;
    logic [2:0]  m_txs, m_rxs;

    logic [31:0]     rq_v [$];
    string           rq_t [$];
    logic [CW_W-1:0] lq_v [$];
    string           lq_t [$];

    function automatic int nsec();
        return ext_mode ? 5 : 4;
    endfunction

    function automatic logic [31:0] idxw(logic [7:0] ti, logic [2:0] ts, logic f,
                                         logic [7:0] ri, logic [2:0] rs);
        return {5'd0, rs, ri, 4'd0, f, ts, ti};
    endfunction

    function automatic logic [CW_W-1:0] mk(int seed);
        logic [CW_W-1:0] r;
        for (int s = 0; s < 5; s++)
            r[s*32 +: 32] = (32'(seed) * 32'h9E37_79B1) ^ (32'h1111_1111 * 32'(s + 1));
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return {5'd0, m_rxs, m_rxi, 4'd0, m_flag[m_txi], m_txs, m_txi};
            2'd1: return (int'(m_txs) < nsec()) ? m_tx[m_txi][m_txs] : 32'd0;
            2'd2: return (int'(m_rxs) < nsec()) ? m_rx[m_rxi][m_rxs] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [CW_W-1:0] exp_link(logic [7:0] x, logic [CW_W-1:0] cw);
        logic [CW_W-1:0] r;
        r = cw;
        if (m_flag[x] && ins_en)
            for (int s = 0; s < nsec(); s++) r[s*32 +: 32] = m_tx[x][s];
        return r;
    endfunction

    task automatic model_wr(logic [1:0] a, logic [31:0] d);
        if (a == 2'd0) begin
            m_txi = d[7:0]; m_txs = d[10:8]; m_rxi = d[23:16]; m_rxs = d[26:24];
            m_flag[d[7:0]] = d[11];
        end else if (a == 2'd1 && int'(m_txs) < nsec()) begin
            m_tx[m_txi][m_txs] = d;
        end
    endtask

    task automatic model_rx(logic [7:0] x, logic [CW_W-1:0] cw);
        for (int s = 0; s < 5; s++) m_rx[x][s] = cw[s*32 +: 32];
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        model_wr(a, d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, string tag);
        rq_v.push_back(exp_read(a));
        rq_t.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic link(logic [7:0] x, logic [CW_W-1:0] cw, string tag);
        lq_v.push_back(exp_link(x, cw));
        lq_t.push_back(tag);
        model_rx(x, cw);
        lnk_vld = 1'b1; lnk_x = x; lnk_cw = cw;
        @(negedge clk);
        lnk_vld = 1'b0;
    endtask

    // Window write and link visit in the same cycle: the link result uses the old entry.
    task automatic wr_link(logic [31:0] d, logic [7:0] x, logic [CW_W-1:0] cw, string tag);
        lq_v.push_back(exp_link(x, cw));
        lq_t.push_back(tag);
        model_rx(x, cw);
        model_wr(2'd1, d);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = d;
        lnk_vld = 1'b1; lnk_x = x; lnk_cw = cw;
        @(negedge clk);
        reg_wr = 1'b0; lnk_vld = 1'b0;
    endtask

    // Monitor: pops and compares whenever the design produces a result.
    always @(negedge clk) begin : mon
        logic [31:0]     ev;
        logic [CW_W-1:0] ew;
        string           t;
        if (rst_n) begin
            if (reg_rvalid) begin
                n_run++;
                if (rq_v.size() == 0) begin
                    n_fail++;
                    $display("FAIL R11 read data without request: act=%h exp=none", reg_rdata);
                end else begin
                    ev = rq_v.pop_front(); t = rq_t.pop_front();
                    if (reg_rdata !== ev) begin
                        n_fail++;
                        $display("FAIL %s read: act=%h exp=%h", t, reg_rdata, ev);
                    end
                end
            end
            if (lnk_vld_o) begin
                n_run++;
                if (lq_v.size() == 0) begin
                    n_fail++;
                    $display("FAIL R7 link output without input: act=%h exp=none", lnk_cw_o);
                end else begin
                    ew = lq_v.pop_front(); t = lq_t.pop_front();
                    if (lnk_cw_o !== ew) begin
                        n_fail++;
                        $display("FAIL %s link: act=%h exp=%h", t, lnk_cw_o, ew);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : drive
        for (int i = 0; i < 256; i++) begin
            m_flag[i] = 1'b0;
            for (int s = 0; s < 5; s++) begin m_tx[i][s] = '0; m_rx[i][s] = '0; end
        end
        m_txi = '0; m_rxi = '0; m_txs = '0; m_rxs = '0;
        rst_n = 1'b0; ext_mode = 1'b0; ins_en = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        lnk_vld = 1'b0; lnk_x = '0; lnk_cw = '0;
        repeat (3) @(negedge clk);
        n_run++;
        if (reg_rvalid !== 1'b0 || lnk_vld_o !== 1'b0 || lnk_cw_o !== '0 || reg_rdata !== '0) begin
            n_fail++;
            $display("FAIL R1 outputs in reset: act=%b%b exp=00", reg_rvalid, lnk_vld_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
        ins_en = 1'b1;
        link(8'd0, mk(1), "R1 no flags set");

        // R2 R3: selector layout and reserved bits
        wr(2'd0, idxw(8'd5, 3'd2, 1'b1, 8'd9, 3'd1) | 32'hF800_F000);
        rd(2'd0, "R2 R3");

        // R5: fill entry 5 sections 0..3 and read them back
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, idxw(8'd5, 3'(s), 1'b1, 8'd9, 3'd0));
            wr(2'd1, 32'hA500_0000 + 32'(s));
        end
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, idxw(8'd5, 3'(s), 1'b1, 8'd9, 3'd0));
            rd(2'd1, "R5");
        end
        // R5: single-section update keeps neighbours and flag
        wr(2'd0, idxw(8'd5, 3'd2, 1'b1, 8'd9, 3'd0));
        wr(2'd1, 32'h0000_1234);
        rd(2'd1, "R5"); rd(2'd0, "R5 flag kept");
        wr(2'd0, idxw(8'd5, 3'd1, 1'b1, 8'd9, 3'd0));
        rd(2'd1, "R5 neighbour");

        // R6: section 4 in normal mode, codes 5..7, then extended mode
        wr(2'd0, idxw(8'd5, 3'd4, 1'b1, 8'd9, 3'd4));
        wr(2'd1, 32'hDEAD_0004);
        rd(2'd1, "R6 normal sec4"); rd(2'd2, "R6 normal sec4");
        wr(2'd0, idxw(8'd5, 3'd7, 1'b1, 8'd9, 3'd6));
        wr(2'd1, 32'hDEAD_0007);
        rd(2'd1, "R6 code7"); rd(2'd2, "R6 code6");
        ext_mode = 1'b1;
        wr(2'd0, idxw(8'd5, 3'd4, 1'b1, 8'd9, 3'd4));
        rd(2'd1, "R6 ext sec4 after ignored write");
        wr(2'd1, 32'hBEEF_0004);
        rd(2'd1, "R6 ext sec4");
        ext_mode = 1'b0;

        // R4: flag belongs to the written entry, others retained
        wr(2'd0, idxw(8'd7, 3'd0, 1'b1, 8'd0, 3'd0));
        rd(2'd0, "R4 set");
        wr(2'd0, idxw(8'd8, 3'd0, 1'b0, 8'd0, 3'd0));
        rd(2'd0, "R4 other entry");
        wr(2'd1, 32'h8888_0000);
        link(8'd7, mk(2), "R4 entry 7 flag kept");
        link(8'd8, mk(3), "R4 entry 8 no flag");

        // R7 R8: substitution in both modes and with global enable low
        link(8'd5, mk(4), "R8 normal mode");
        ext_mode = 1'b1;
        link(8'd5, mk(5), "R8 extended mode");
        ins_en = 1'b0;
        link(8'd5, mk(6), "R7 global enable low");
        ins_en = 1'b1;
        ext_mode = 1'b0;

        // R9: receive capture and window
        link(8'd9, mk(7), "R9 capture");
        link(8'd10, mk(8), "R9 capture");
        ext_mode = 1'b1;
        for (int s = 0; s < 5; s++) begin
            wr(2'd0, idxw(8'd5, 3'd0, 1'b1, 8'd9, 3'(s)));
            rd(2'd2, "R9");
        end
        wr(2'd0, idxw(8'd5, 3'd0, 1'b1, 8'd10, 3'd3));
        rd(2'd2, "R9 second entry");
        ext_mode = 1'b0;
        wr(2'd0, idxw(8'd5, 3'd0, 1'b1, 8'd9, 3'd4));
        rd(2'd2, "R6 rx sec4 normal");

        // R10: write collides with substitution of the same entry
        wr_link(32'h0C0C_0C0C, 8'd5, mk(9), "R10 old content");
        link(8'd5, mk(10), "R10 new content");

        // R11: spare address
        rd(2'd3, "R11 spare");

        // R7: a stream of positions with mixed enables and modes
        for (int i = 0; i < 40; i++) begin
            ins_en   = (i % 3) != 0;
            ext_mode = (i % 5) == 0;
            link(8'((i * 37) % 12), mk(100 + i), "R7 stream");
        end
        ext_mode = 1'b0;
        wr(2'd0, idxw(8'd4, 3'd0, 1'b0, 8'd4, 3'd2));
        rd(2'd2, "R9 after stream");

        repeat (4) @(negedge clk);
        n_run++;
        if (rq_v.size() != 0 || lq_v.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing results: act=%0d exp=0", rq_v.size() + lq_v.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule